// File: doc/BRIEF.md
# Complementary dead-time inserter

This block takes one PWM level from an upstream compare channel and produces a complementary pair of gate drives. The first drive is in phase with the input and the second is its inverse. Every input transition switches the drive that is turning off at once. The drive that is turning on is held back for a programmable dead time, so the two drives are never active together. This protects the two switches of a half bridge during their turn-off interval.

The dead time is a 16-bit count of prescaled ticks. A 3-bit divider select sets the tick rate to the clock divided by a power of two. A 3-bit mode field enables the function, and only one code value turns it on. A polarity bit chooses between active-high and active-low drive pins. When the mode is not selected, or when the upstream compare channel reports that it is stopped, both drives are held at their inactive level.

Top module: `dtgen_pair`

## Requirements
- R1: In steady state with the mode selected and the compare channel running, the logical state of `gate_pos` equals the input level and the logical state of `gate_neg` equals its inverse.
- R2: The logical states of `gate_pos` and `gate_neg` are never both active at the same time.
- R3: When the input changes, the drive that was active goes inactive right after the clock edge that first samples the new input level.
- R4: When the input changes, the drive that turns on goes active exactly `dead_ticks × divider` clock edges after the sampling edge, and is inactive until then.
- R5: `pre_sel` gives a divider of 2 to the power of its value: 3'b000 divides by 1, 3'b001 by 2, and so on up to 3'b111 dividing by 128.
- R6: With `dead_ticks` equal to 0, the complementary pair follows the input with one register of latency and no gap.
- R7: If the input changes again before the dead time has elapsed, the pending turn-on is dropped, both drives stay inactive, and a full new dead time is counted from the new sampling edge.
- R8: The function runs only when `mode_sel` is 3'b100. Any other value forces both drives inactive after the next clock edge.
- R9: While `cmp_run` is low, both drives are inactive after the next clock edge.
- R10: With `inv_pol` at 0 the pins are active high. With `inv_pol` at 1 both pins are inverted, so their inactive level is 1.
- R11: When the function becomes enabled, both drives stay inactive. The drive that matches the current input level then turns on after a full dead time, just as after an input transition.
- R12: During and right after reset, both drives are at their inactive level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pwm_in | input | 1 | PWM level from the upstream compare channel |
| mode_sel | input | 3 | Waveform mode code; 3'b100 enables dead-time insertion |
| cmp_run | input | 1 | High while the upstream compare channel is running |
| inv_pol | input | 1 | 0 selects active-high pins, 1 selects active-low pins |
| pre_sel | input | 3 | Tick divider select, divide by 2^pre_sel |
| dead_ticks | input | 16 | Dead time in prescaled ticks |
| gate_pos | output | 1 | Drive in phase with the input |
| gate_neg | output | 1 | Drive in antiphase with the input |

## Verification
The bench builds the block with a 16-bit dead-time width and a 3-bit divider select. This gives it the whole divider range from 1 to 128, including the last code, where the tick counter wraps at its widest value. Dead-time values stay small so that, at every divider, turn-on delays of many clock cycles fit inside short input pulses. That places the cancel-and-restart case and the zero-delay pass-through within reach of the random segments.

// File: rtl/dtgen_pkg.sv
package dtgen_pkg;

  // Mode code that enables complementary dead-time insertion.
  localparam logic [2:0] MODE_DEADTIME = 3'b100;

  // Logical (polarity-free) state of the drive pair.
  typedef struct packed {
    logic pos;
    logic neg;
  } drive_pair_t;

  localparam drive_pair_t PAIR_IDLE = '{pos: 1'b0, neg: 1'b0};

endpackage

// File: rtl/dtgen_prescale.sv
module dtgen_prescale #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PC_W = (1 << SEL_W) - 1;

  logic [PC_W-1:0] pre_q, pre_d;
  logic [PC_W:0]   lim;
  logic            pre_en;

  // Terminal count of the divider is 2^sel - 1.
  assign lim  = ({{PC_W{1'b0}}, 1'b1} << sel) - {{PC_W{1'b0}}, 1'b1};
  assign tick = run && ({1'b0, pre_q} == lim);

  always_comb begin
    pre_en = restart || run || (pre_q != '0);
    if (restart || !run || tick) begin
      pre_d = '0;
    end else begin
      pre_d = pre_q + {{(PC_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (pre_en) begin
      pre_q <= pre_d;
    end
  end

endmodule

// File: rtl/dtgen_delay.sv
module dtgen_delay #(
  parameter int DT_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            abort,
  input  logic            load,
  input  logic [DT_W-1:0] load_val,
  input  logic            tick,
  output logic            pend,
  output logic            expire
);
  logic [DT_W-1:0] cnt_q, cnt_d;
  logic            pend_q, pend_d;
  logic            upd_en;

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    expire = 1'b0;
    if (abort) begin
      pend_d = 1'b0;
    end else if (load) begin
      cnt_d  = load_val;
      pend_d = (load_val != '0);
    end else if (pend_q && tick) begin
      if (cnt_q == {{(DT_W-1){1'b0}}, 1'b1}) begin
        expire = 1'b1;
        pend_d = 1'b0;
      end else begin
        cnt_d = cnt_q - {{(DT_W-1){1'b0}}, 1'b1};
      end
    end
  end

  assign upd_en = abort || load || (pend_q && tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

endmodule

// File: rtl/dtgen_steer.sv
module dtgen_steer
  import dtgen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic edge_seen,
  input  logic zero_dt,
  input  logic expire,
  input  logic lvl,
  input  logic inv_pol,
  output logic pin_pos,
  output logic pin_neg
);
  drive_pair_t pair_q, pair_d;
  logic        pair_en;

  always_comb begin
    pair_en = 1'b1;
    if (!active) begin
      pair_d = PAIR_IDLE;
    end else if (edge_seen) begin
      // Turning-off side drops now; turning-on side waits unless no dead time.
      pair_d = zero_dt ? '{pos: lvl, neg: !lvl} : PAIR_IDLE;
    end else if (expire) begin
      pair_d = '{pos: lvl, neg: !lvl};
    end else begin
      pair_d  = pair_q;
      pair_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q <= PAIR_IDLE;
    end else if (pair_en) begin
      pair_q <= pair_d;
    end
  end

  assign pin_pos = pair_q.pos ^ inv_pol;
  assign pin_neg = pair_q.neg ^ inv_pol;

endmodule

// File: rtl/dtgen_pair.sv
module dtgen_pair
  import dtgen_pkg::*;
#(
  parameter int DT_W  = 16,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_in,
  input  logic [2:0]       mode_sel,
  input  logic             cmp_run,
  input  logic             inv_pol,
  input  logic [SEL_W-1:0] pre_sel,
  input  logic [DT_W-1:0]  dead_ticks,
  output logic             gate_pos,
  output logic             gate_neg
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       act;
  logic       run_q;
  logic       prev_q;
  logic       edge_seen;
  logic       zero_dt;
  logic       tick;
  logic       pend;
  logic       expire;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  assign act       = (mode_sel == MODE_DEADTIME) && cmp_run;
  assign edge_seen = act && (!run_q || (pwm_in != prev_q));
  assign zero_dt   = (dead_ticks == '0);

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      run_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      run_q  <= act;
      prev_q <= pwm_in;
    end
  end

  dtgen_prescale #(.SEL_W(SEL_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .restart (edge_seen),
    .run     (pend),
    .sel     (pre_sel),
    .tick    (tick)
  );

  dtgen_delay #(.DT_W(DT_W)) u_dly (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .abort    (!act),
    .load     (edge_seen),
    .load_val (dead_ticks),
    .tick     (tick),
    .pend     (pend),
    .expire   (expire)
  );

  dtgen_steer u_steer (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .active    (act),
    .edge_seen (edge_seen),
    .zero_dt   (zero_dt),
    .expire    (expire),
    .lvl       (pwm_in),
    .inv_pol   (inv_pol),
    .pin_pos   (gate_pos),
    .pin_neg   (gate_neg)
  );

endmodule

// File: rtl/dtgen_pair_chk.sv
module dtgen_pair_chk #(
  parameter int DT_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pwm_in,
  input logic [2:0]      mode_sel,
  input logic            cmp_run,
  input logic            inv_pol,
  input logic [DT_W-1:0] dead_ticks,
  input logic            gate_pos,
  input logic            gate_neg,
  input logic            pend
);
  logic lpos, lneg, en_now;
  assign lpos   = gate_pos ^ inv_pol;
  assign lneg   = gate_neg ^ inv_pol;
  assign en_now = (mode_sel == 3'b100) && cmp_run;

  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(lpos && lneg));

  assert_pos_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lpos && !pwm_in) |=> !lpos);

  assert_neg_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lneg && pwm_in) |=> !lneg);

  assert_pos_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lpos) |-> $past(pwm_in));

  assert_neg_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lneg) |-> !$past(pwm_in));

  assert_idle_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != 3'b100) |=> (!lpos && !lneg));

  assert_idle_when_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_run |=> (!lpos && !lneg));

  assert_zero_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_now && dead_ticks == '0 && !pend) |=> (lpos == $past(pwm_in) && lneg == !$past(pwm_in)));

endmodule

bind dtgen_pair dtgen_pair_chk #(.DT_W(DT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .pwm_in     (pwm_in),
  .mode_sel   (mode_sel),
  .cmp_run    (cmp_run),
  .inv_pol    (inv_pol),
  .dead_ticks (dead_ticks),
  .gate_pos   (gate_pos),
  .gate_neg   (gate_neg),
  .pend       (pend)
);

// File: tb/dtgen_pair_test.sv
module dtgen_pair_test;
  localparam int CLK_PERIOD = 10;
  localparam int DT_W  = 16;
  localparam int SEL_W = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             pwm_in;
  logic [2:0]       mode_sel;
  logic             cmp_run;
  logic             inv_pol;
  logic [SEL_W-1:0] pre_sel;
  logic [DT_W-1:0]  dead_ticks;
  logic             gate_pos, gate_neg;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  string tag   = "R12";

  always #(CLK_PERIOD/2) clk = ~clk;

  dtgen_pair #(.DT_W(DT_W), .SEL_W(SEL_W)) uut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .mode_sel(mode_sel),
    .cmp_run(cmp_run), .inv_pol(inv_pol), .pre_sel(pre_sel),
    .dead_ticks(dead_ticks), .gate_pos(gate_pos), .gate_neg(gate_neg)
  );

  // Reference model built from the requirements: a countdown in clock cycles.
  logic m_run, m_prev, m_pend, m_pos, m_neg;
  int   m_left;

  function automatic int delay_cycles(input int ticks, input int sel);
    return ticks * (1 << sel);
  endfunction

  function automatic bit enabled(input logic [2:0] m, input logic r);
    return (m == 3'b100) && r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run <= 0; m_prev <= 0; m_pend <= 0; m_pos <= 0; m_neg <= 0; m_left <= 0;
    end else begin
      m_run  <= enabled(mode_sel, cmp_run);
      m_prev <= pwm_in;
      if (!enabled(mode_sel, cmp_run)) begin
        m_pend <= 0; m_pos <= 0; m_neg <= 0;
      end else if (!m_run || pwm_in != m_prev) begin
        if (dead_ticks == 0) begin
          m_pend <= 0; m_pos <= pwm_in; m_neg <= !pwm_in;
        end else begin
          m_pend <= 1; m_pos <= 0; m_neg <= 0;
          m_left <= delay_cycles(int'(dead_ticks), int'(pre_sel));
        end
      end else if (m_pend) begin
        if (m_left == 1) begin
          m_pend <= 0; m_pos <= pwm_in; m_neg <= !pwm_in;
        end else begin
          m_left <= m_left - 1;
        end
      end
    end
  end

  task automatic check_pins();
    logic ep, en;
    ep = m_pos ^ inv_pol;
    en = m_neg ^ inv_pol;
    n_chk++;
    if (gate_pos !== ep || gate_neg !== en) begin
      n_bad++;
      $display("FAIL %s: pos=%b neg=%b expected pos=%b neg=%b at %0t",
               tag, gate_pos, gate_neg, ep, en, $time);
    end
  endtask

  // Sample on every falling edge, away from the active edge.
  always @(negedge clk) if (rst_n && !done) check_pins();

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; pwm_in = 0; mode_sel = 3'b000; cmp_run = 0;
    inv_pol = 0; pre_sel = 0; dead_ticks = 0;
    cyc(3);
    // R12: pins idle while reset is held.
    tag = "R12";
    n_chk++;
    if (gate_pos !== 1'b0 || gate_neg !== 1'b0) begin
      n_bad++;
      $display("FAIL R12: pos=%b neg=%b expected pos=0 neg=0", gate_pos, gate_neg);
    end
    rst_n = 1;
    cyc(5);

    // R11, R4, R5: enable with dead time 3 at divide-by-2, then long holds (R1).
    tag = "R11 R4 R5 R1"; dead_ticks = 3; pre_sel = 3'b001;
    mode_sel = 3'b100; cmp_run = 1;
    cyc(12);
    for (int k = 0; k < 6; k++) begin pwm_in = ~pwm_in; cyc(15); end

    // R3 and R4 at divide-by-1, a single-tick dead time.
    tag = "R3 R4"; mode_sel = 0; cyc(2); dead_ticks = 1; pre_sel = 0; mode_sel = 3'b100;
    cyc(4);
    for (int k = 0; k < 6; k++) begin pwm_in = ~pwm_in; cyc(3); end

    // R6: zero dead time passes the pair straight through.
    tag = "R6"; mode_sel = 0; cyc(2); dead_ticks = 0; mode_sel = 3'b100;
    for (int k = 0; k < 40; k++) begin pwm_in = $urandom_range(0, 1); cyc(1); end

    // R7 and R2: toggles faster than the dead time keep restarting it.
    tag = "R7 R2"; mode_sel = 0; cyc(2); dead_ticks = 10; pre_sel = 0; mode_sel = 3'b100;
    cyc(14);
    for (int k = 0; k < 8; k++) begin pwm_in = ~pwm_in; cyc(4); end
    cyc(14);

    // R5: every divider code, including divide-by-128.
    for (int s = 0; s < 8; s++) begin
      tag = "R5"; mode_sel = 0; cyc(2);
      pre_sel = SEL_W'(s); dead_ticks = 2; mode_sel = 3'b100;
      cyc(2 * (1 << s) + 3);
      pwm_in = ~pwm_in; cyc(2 * (1 << s) + 3);
    end

    // R8: other mode codes hold both drives idle.
    tag = "R8"; dead_ticks = 0; pre_sel = 0;
    for (int m = 0; m < 8; m++) begin
      if (m != 4) begin
        mode_sel = 3'(m);
        for (int k = 0; k < 5; k++) begin pwm_in = ~pwm_in; cyc(2); end
      end
    end

    // R9: stopped compare channel holds both drives idle.
    tag = "R9"; mode_sel = 3'b100; cmp_run = 1; cyc(3);
    cmp_run = 0;
    for (int k = 0; k < 6; k++) begin pwm_in = ~pwm_in; cyc(2); end
    cmp_run = 1; cyc(3);

    // R10: active-low pins.
    tag = "R10"; inv_pol = 1;
    for (int k = 0; k < 20; k++) begin pwm_in = $urandom_range(0, 1); cyc(2); end
    inv_pol = 0;

    // Random segments: R1, R2, R3, R4, R7, R9, R11 under mixed settings.
    tag = "R2 R3 R4 R7 R11 random";
    for (int seg = 0; seg < 60; seg++) begin
      mode_sel = 0; cyc(2);
      dead_ticks = DT_W'($urandom_range(0, 20));
      pre_sel    = SEL_W'($urandom_range(0, 3));
      inv_pol    = 1'($urandom_range(0, 1));
      mode_sel   = 3'b100; cmp_run = 1;
      for (int k = 0; k < 10; k++) begin
        pwm_in = ~pwm_in;
        if ($urandom_range(0, 15) == 0) cmp_run = 0;
        else cmp_run = 1;
        cyc($urandom_range(1, delay_cycles(int'(dead_ticks), int'(pre_sel)) + 8));
      end
    end

    cyc(4);
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
    finish_run();
  end

endmodule